// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block paces and sequences the digital back end of a decimating sigma-delta converter. A single phase counter spaces output words 32 master clocks apart and times three jobs. It holds off the data-ready flag while the decimation filter settles after a restart. It gates the modulator and filter clock during standby. It steps the front-end multiplexer through a self-calibration, pulsing a strobe when each correction register should capture its averaged result. The modulator, the filter arithmetic and the analog switches sit outside the block and see only its strobes and selects.

Data-ready is a single-clock pulse, one per output word, once valid data exists. Its idle level follows the interface-mode pin: idle high in parallel mode and idle low in serial mode, with the pulse at the opposite level. The sync and calibration-start inputs pass through two sampling flops and act on their rising edges. Standby has the highest priority, then sync, then calibration start. A calibration is aborted by sync or by standby.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted, data-ready sits at its idle level, clk_en is 1, mux_sel is 0 and all strobes are 0. After reset is released, the first active data-ready appears on the 2080th rising edge.
- R2: In steady running, data-ready is active for exactly one clock out of every 32.
- R3: The idle level of data-ready equals par_mode (1 = parallel, idle high; 0 = serial, idle low). An active pulse takes the opposite level.
- R4: The second rising edge that finds sync_in high raises filt_rst for one clock. The first active data-ready follows exactly 2080 clocks after filt_rst. A sync held high triggers only once.
- R5: clk_en drops on the edge after standby_req is sampled high, and data-ready stays idle during standby. On release, filt_rst pulses together with clk_en returning to 1, and the first data-ready follows 2080 clocks later.
- R6: A unipolar calibration starts on the second edge that finds cal_start high. mux_sel encodes the input path: 0 = input pins, 1 = inputs shorted, 2 = positive to reference and negative to ground, 3 = positive to ground and negative to reference. The sequence is mux_sel 1 for 2304 clocks, then ofs_load with mux_sel 2 for 2304 clocks, then gpos_load with mux_sel 0. The first data-ready comes 6688 clocks after mux_sel leaves 0, within the 6720-clock limit.
- R7: When bipolar is high at the start, a third phase follows gpos_load: mux_sel 3 for 2304 clocks, ending with gneg_load and mux_sel 0. The first data-ready comes 8992 clocks after the start, within the 9024-clock limit. A later change of bipolar does not affect the running calibration.
- R8: A sync edge during calibration returns mux_sel to 0 and pulses filt_rst in the same clock. No load strobe follows, and data-ready resumes 2080 clocks later.
- R9: Standby during calibration returns mux_sel to 0 on the same edge as clk_en falls, and no load strobe follows. Release behaves as in R5.
- R10: Sync and calibration-start edges that arrive while standby is asserted are dropped. After release only the standby-exit filt_rst occurs, and no calibration starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_req | input | 1 | Level request for low-power standby |
| sync_in | input | 1 | Filter synchronization request, rising edge |
| cal_start | input | 1 | Self-calibration request, rising edge |
| bipolar | input | 1 | 1 = bipolar input range, sampled at calibration start |
| par_mode | input | 1 | 1 = parallel interface, 0 = serial interface |
| drdy | output | 1 | Data-ready flag, idle level equals par_mode |
| filt_rst | output | 1 | One-clock decimation filter reset strobe |
| mux_sel | output | 2 | Front-end input path select, encoding in R6 |
| ofs_load | output | 1 | Offset register capture strobe |
| gpos_load | output | 1 | Positive gain register capture strobe |
| gneg_load | output | 1 | Negative gain register capture strobe (bipolar) |
| clk_en | output | 1 | Modulator and filter clock enable |

## Verification
The bench times every strobe, select change and data-ready pulse to the exact clock. Three errors are targeted: a hold that is off by a clock, a calibration phase one clock too long or short, and a mis-encoded mux path. Each of these shifts or mislabels an event against the expected log. Sync and standby are injected in the middle of a calibration. A design that fails to abort would keep stepping the multiplexer or emit a load strobe that was never expected. Requests pulsed while standby is held probe whether edges are queued rather than dropped. A queued edge would show up after release as a second filter reset or a stray calibration. Switching the interface mode catches an inverted idle level.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_RUN     = 3'd1,
    ST_STBY    = 3'd2,
    ST_CAL_OFS = 3'd3,
    ST_CAL_GP  = 3'd4,
    ST_CAL_GN  = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    PATH_INPUT   = 2'd0,
    PATH_SHORT   = 2'd1,
    PATH_REF_POS = 2'd2,
    PATH_REF_NEG = 2'd3
  } path_sel_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= 1'b0;
        stage2_q <= 1'b0;
      end else begin
        stage1_q <= din[i];
        stage2_q <= stage1_q;
      end
    end
    assign rise[i] = stage1_q & ~stage2_q;
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else            count <= count + 1'b1;
  end

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int WORD_DIV   = 32,
  parameter int SETTLE     = 2080,
  parameter int CAL_SETTLE = 2048,
  parameter int AVG_N      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       sync_rise,
  input  logic       cal_rise,
  input  logic       bipolar,
  output logic [1:0] path_sel,
  output logic       filt_rst,
  output logic       ofs_load,
  output logic       gpos_load,
  output logic       gneg_load,
  output logic       word_pulse,
  output logic       run_en
);

  localparam int PHASE_LEN = CAL_SETTLE + AVG_N * WORD_DIV;
  localparam int CNT_MAX   = max2(max2(PHASE_LEN, SETTLE), WORD_DIV);
  localparam int CW        = $clog2(CNT_MAX + 1);

  seq_state_e state_q, state_d;
  path_sel_e  path_q, path_d;
  logic       bip_q, bip_d;
  logic       frst_d, ofs_d, gp_d, gn_d, word_d;
  logic       clr;
  logic [CW-1:0] cnt;

  adc_seq_timer #(.W(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr),
    .count (cnt)
  );

  wire hold_end  = (cnt == CW'(SETTLE - 1));
  wire word_end  = (cnt == CW'(WORD_DIV - 1));
  wire phase_end = (cnt == CW'(PHASE_LEN - 1));
  wire can_cal   = (state_q == ST_HOLD) || (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    path_d  = path_q;
    bip_d   = bip_q;
    clr     = 1'b0;
    frst_d  = 1'b0;
    ofs_d   = 1'b0;
    gp_d    = 1'b0;
    gn_d    = 1'b0;
    word_d  = 1'b0;
    if (standby) begin
      // standby overrides everything and drops any request
      if (state_q != ST_STBY) begin
        state_d = ST_STBY;
        path_d  = PATH_INPUT;
      end
    end else if (state_q == ST_STBY) begin
      state_d = ST_HOLD;
      clr     = 1'b1;
      frst_d  = 1'b1;
    end else if (sync_rise) begin
      state_d = ST_HOLD;
      path_d  = PATH_INPUT;
      clr     = 1'b1;
      frst_d  = 1'b1;
    end else if (cal_rise && can_cal) begin
      state_d = ST_CAL_OFS;
      path_d  = PATH_SHORT;
      bip_d   = bipolar;
      clr     = 1'b1;
    end else begin
      unique case (state_q)
        ST_HOLD: if (hold_end) begin
          state_d = ST_RUN;
          clr     = 1'b1;
          word_d  = 1'b1;
        end
        ST_RUN: if (word_end) begin
          clr    = 1'b1;
          word_d = 1'b1;
        end
        ST_CAL_OFS: if (phase_end) begin
          state_d = ST_CAL_GP;
          path_d  = PATH_REF_POS;
          ofs_d   = 1'b1;
          clr     = 1'b1;
        end
        ST_CAL_GP: if (phase_end) begin
          gp_d = 1'b1;
          clr  = 1'b1;
          if (bip_q) begin
            state_d = ST_CAL_GN;
            path_d  = PATH_REF_NEG;
          end else begin
            state_d = ST_HOLD;
            path_d  = PATH_INPUT;
          end
        end
        ST_CAL_GN: if (phase_end) begin
          state_d = ST_HOLD;
          path_d  = PATH_INPUT;
          gn_d    = 1'b1;
          clr     = 1'b1;
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HOLD;
      path_q     <= PATH_INPUT;
      bip_q      <= 1'b0;
      filt_rst   <= 1'b0;
      ofs_load   <= 1'b0;
      gpos_load  <= 1'b0;
      gneg_load  <= 1'b0;
      word_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      path_q     <= path_d;
      bip_q      <= bip_d;
      filt_rst   <= frst_d;
      ofs_load   <= ofs_d;
      gpos_load  <= gp_d;
      gneg_load  <= gn_d;
      word_pulse <= word_d;
    end
  end

  assign path_sel = path_q;
  assign run_en   = (state_q != ST_STBY);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int WORD_DIV   = 32,
  parameter int SETTLE     = 2080,
  parameter int CAL_SETTLE = 2048,
  parameter int AVG_N      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby_req,
  input  logic       sync_in,
  input  logic       cal_start,
  input  logic       bipolar,
  input  logic       par_mode,
  output logic       drdy,
  output logic       filt_rst,
  output logic [1:0] mux_sel,
  output logic       ofs_load,
  output logic       gpos_load,
  output logic       gneg_load,
  output logic       clk_en
);

  localparam int NREQ = 2;

  logic [NREQ-1:0] req_rise;
  logic            word_pulse;

  adc_seq_edge #(.N(NREQ)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({cal_start, sync_in}),
    .rise  (req_rise)
  );

  adc_seq_core #(
    .WORD_DIV   (WORD_DIV),
    .SETTLE     (SETTLE),
    .CAL_SETTLE (CAL_SETTLE),
    .AVG_N      (AVG_N)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby_req),
    .sync_rise  (req_rise[0]),
    .cal_rise   (req_rise[1]),
    .bipolar    (bipolar),
    .path_sel   (mux_sel),
    .filt_rst   (filt_rst),
    .ofs_load   (ofs_load),
    .gpos_load  (gpos_load),
    .gneg_load  (gneg_load),
    .word_pulse (word_pulse),
    .run_en     (clk_en)
  );

  // idle level follows the interface mode; a word pulse inverts it
  assign drdy = par_mode ^ word_pulse;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int WORD_DIV = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       standby_req,
  input logic       par_mode,
  input logic       drdy,
  input logic       filt_rst,
  input logic [1:0] mux_sel,
  input logic       ofs_load,
  input logic       gpos_load,
  input logic       gneg_load,
  input logic       clk_en
);

  localparam int GW = $clog2(WORD_DIV + 1);

  logic          active;
  logic          seen_q;
  logic [GW-1:0] gap_q;

  assign active = drdy ^ par_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (active) begin
      seen_q <= 1'b1;
      gap_q  <= '0;
    end else if (gap_q != GW'(WORD_DIV)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> !active);

  a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (active && seen_q) |-> (gap_q >= GW'(WORD_DIV - 1)));

  a_r4_frst_single: assert property (@(posedge clk) disable iff (!rst_n)
    filt_rst |=> !filt_rst);

  a_r5_stby_gates_clk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_req |=> !clk_en);

  a_r5_stby_drdy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !active);

  a_r9_stby_path_input: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (mux_sel == 2'd0));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({filt_rst, ofs_load, gpos_load, gneg_load}));

  a_r6_ofs_then_refpos: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_load |-> (mux_sel == 2'd2));

  a_r7_gpos_next_path: assert property (@(posedge clk) disable iff (!rst_n)
    gpos_load |-> (mux_sel == 2'd3 || mux_sel == 2'd0));

  a_r7_gneg_back_input: assert property (@(posedge clk) disable iff (!rst_n)
    gneg_load |-> (mux_sel == 2'd0));

  a_r6_no_drdy_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != 2'd0) |-> !active);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.WORD_DIV(WORD_DIV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .standby_req (standby_req),
  .par_mode    (par_mode),
  .drdy        (drdy),
  .filt_rst    (filt_rst),
  .mux_sel     (mux_sel),
  .ofs_load    (ofs_load),
  .gpos_load   (gpos_load),
  .gneg_load   (gneg_load),
  .clk_en      (clk_en)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  localparam int EV_FRST = 1, EV_OFS = 2, EV_GP = 3, EV_GN = 4, EV_DRDY = 5;
  localparam int EV_CELO = 6, EV_CEHI = 7, EV_MUX0 = 10;
  localparam int HOLD = 2080, PH = 2304;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_req = 1'b0, sync_in = 1'b0, cal_start = 1'b0;
  logic bipolar = 1'b0, par_mode = 1'b1;
  logic drdy, filt_rst, ofs_load, gpos_load, gneg_load, clk_en;
  logic [1:0] mux_sel;

  int cyc = 0;
  int checks = 0, failures = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  string cur_tag = "R1";
  int qk[$];
  int qc[$];
  string qt[$];
  logic [1:0] mux_prev = 2'd0;
  logic ce_prev = 1'b1;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .standby_req(standby_req), .sync_in(sync_in),
    .cal_start(cal_start), .bipolar(bipolar), .par_mode(par_mode),
    .drdy(drdy), .filt_rst(filt_rst), .mux_sel(mux_sel), .ofs_load(ofs_load),
    .gpos_load(gpos_load), .gneg_load(gneg_load), .clk_en(clk_en)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string ev_name(int k);
    case (k)
      EV_FRST: return "filt_rst";
      EV_OFS:  return "ofs_load";
      EV_GP:   return "gpos_load";
      EV_GN:   return "gneg_load";
      EV_DRDY: return "drdy_active";
      EV_CELO: return "clk_en_fall";
      EV_CEHI: return "clk_en_rise";
      default: return $sformatf("mux_sel=%0d", k - EV_MUX0);
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_ev(int k, int c, string tag);
    qk.push_back(k);
    qc.push_back(c);
    qt.push_back(tag);
  endtask

  // scoreboard monitor: every observed event must match the queue front
  task automatic observe(int k);
    if (qk.size() > 0 && qk[0] == k) begin
      check(qc[0] == cyc, qt[0], {ev_name(k), " cycle"}, cyc, qc[0]);
      void'(qk.pop_front());
      void'(qc.pop_front());
      void'(qt.pop_front());
    end else begin
      checks++;
      failures++;
      $display("FAIL %s unexpected %s actual=cycle %0d expected=%s", cur_tag,
               ev_name(k), cyc, (qk.size() > 0) ? ev_name(qk[0]) : "none");
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (filt_rst)  observe(EV_FRST);
      if (ofs_load)  observe(EV_OFS);
      if (gpos_load) observe(EV_GP);
      if (gneg_load) observe(EV_GN);
      if (mux_sel != mux_prev) observe(EV_MUX0 + int'(mux_sel));
      if (drdy != par_mode) observe(EV_DRDY);
      if (clk_en != ce_prev) observe(clk_en ? EV_CEHI : EV_CELO);
    end
    mux_prev = mux_sel;
    ce_prev  = clk_en;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align();
    do @(negedge clk); while (drdy == par_mode);
    tick(2);
  endtask

  task automatic close_scn(int last);
    while (cyc < last + 2) @(negedge clk);
    mon_en = 1'b0;
    while (qk.size() > 0) begin
      checks++;
      failures++;
      $display("FAIL %s missing %s actual=absent expected=cycle %0d",
               qt[0], ev_name(qk[0]), qc[0]);
      void'(qk.pop_front());
      void'(qc.pop_front());
      void'(qt.pop_front());
    end
  endtask

  initial begin : watchdog
    while (cyc < 100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL %s watchdog actual=%0d expected<100000", cur_tag, cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int c, s, r;
    // R1: reset state
    tick(3);
    check(drdy == 1'b1, "R1", "drdy in reset", int'(drdy), 1);
    check(clk_en == 1'b1, "R1", "clk_en in reset", int'(clk_en), 1);
    check(mux_sel == 2'd0, "R1", "mux_sel in reset", int'(mux_sel), 0);
    check({filt_rst, ofs_load, gpos_load, gneg_load} == 4'd0, "R1",
          "strobes in reset", int'({filt_rst, ofs_load, gpos_load, gneg_load}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    c = cyc;
    cur_tag = "R1";
    mon_en = 1'b1;
    expect_ev(EV_DRDY, c + HOLD, "R1");
    expect_ev(EV_DRDY, c + HOLD + 32, "R2");
    tick(100);
    check(drdy == 1'b1, "R3", "parallel idle level", int'(drdy), 1);
    close_scn(c + HOLD + 32);

    // R4: sync in parallel mode, held high
    align();
    c = cyc;
    cur_tag = "R4";
    mon_en = 1'b1;
    sync_in = 1'b1;
    expect_ev(EV_FRST, c + 2, "R4");
    expect_ev(EV_DRDY, c + 2 + HOLD, "R4");
    expect_ev(EV_DRDY, c + 2 + HOLD + 32, "R2");
    close_scn(c + 2 + HOLD + 32);
    sync_in = 1'b0;

    // R3: serial mode polarity
    align();
    par_mode = 1'b0;
    tick(1);
    check(drdy == 1'b0, "R3", "serial idle level", int'(drdy), 0);
    align();
    c = cyc;
    cur_tag = "R3";
    mon_en = 1'b1;
    sync_in = 1'b1;
    expect_ev(EV_FRST, c + 2, "R3");
    expect_ev(EV_DRDY, c + 2 + HOLD, "R3");
    expect_ev(EV_DRDY, c + 2 + HOLD + 32, "R3");
    tick(6);
    sync_in = 1'b0;
    tick(100);
    check(drdy == 1'b0, "R3", "serial hold level", int'(drdy), 0);
    close_scn(c + 2 + HOLD + 32);
    par_mode = 1'b1;

    // R5 and R10: standby with requests dropped
    align();
    c = cyc;
    cur_tag = "R5";
    mon_en = 1'b1;
    standby_req = 1'b1;
    expect_ev(EV_CELO, c + 1, "R5");
    tick(40);
    check(drdy == 1'b1, "R5", "drdy idle in standby", int'(drdy), 1);
    cur_tag = "R10";
    sync_in = 1'b1;
    cal_start = 1'b1;
    tick(3);
    sync_in = 1'b0;
    cal_start = 1'b0;
    tick(10);
    r = cyc;
    standby_req = 1'b0;
    expect_ev(EV_FRST, r + 1, "R10");
    expect_ev(EV_CEHI, r + 1, "R5");
    expect_ev(EV_DRDY, r + 1 + HOLD, "R5");
    expect_ev(EV_DRDY, r + 1 + HOLD + 32, "R10");
    close_scn(r + 1 + HOLD + 32);

    // R6: unipolar calibration
    align();
    c = cyc;
    cur_tag = "R6";
    mon_en = 1'b1;
    bipolar = 1'b0;
    cal_start = 1'b1;
    expect_ev(EV_MUX0 + 1, c + 2, "R6");
    expect_ev(EV_OFS, c + 2 + PH, "R6");
    expect_ev(EV_MUX0 + 2, c + 2 + PH, "R6");
    expect_ev(EV_GP, c + 2 + 2 * PH, "R6");
    expect_ev(EV_MUX0 + 0, c + 2 + 2 * PH, "R6");
    expect_ev(EV_DRDY, c + 2 + 6688, "R6");
    expect_ev(EV_DRDY, c + 2 + 6688 + 32, "R2");
    tick(5);
    cal_start = 1'b0;
    close_scn(c + 2 + 6688 + 32);

    // R7: bipolar calibration, select changed after start
    align();
    c = cyc;
    cur_tag = "R7";
    mon_en = 1'b1;
    bipolar = 1'b1;
    cal_start = 1'b1;
    expect_ev(EV_MUX0 + 1, c + 2, "R7");
    expect_ev(EV_OFS, c + 2 + PH, "R7");
    expect_ev(EV_MUX0 + 2, c + 2 + PH, "R7");
    expect_ev(EV_GP, c + 2 + 2 * PH, "R7");
    expect_ev(EV_MUX0 + 3, c + 2 + 2 * PH, "R7");
    expect_ev(EV_GN, c + 2 + 3 * PH, "R7");
    expect_ev(EV_MUX0 + 0, c + 2 + 3 * PH, "R7");
    expect_ev(EV_DRDY, c + 2 + 8992, "R7");
    expect_ev(EV_DRDY, c + 2 + 8992 + 32, "R7");
    tick(5);
    cal_start = 1'b0;
    tick(10);
    bipolar = 1'b0;
    close_scn(c + 2 + 8992 + 32);

    // R8: sync aborts calibration
    align();
    c = cyc;
    cur_tag = "R8";
    mon_en = 1'b1;
    bipolar = 1'b1;
    cal_start = 1'b1;
    expect_ev(EV_MUX0 + 1, c + 2, "R8");
    tick(5);
    cal_start = 1'b0;
    while (cyc < c + 1000) @(negedge clk);
    s = cyc;
    sync_in = 1'b1;
    expect_ev(EV_FRST, s + 2, "R8");
    expect_ev(EV_MUX0 + 0, s + 2, "R8");
    expect_ev(EV_DRDY, s + 2 + HOLD, "R8");
    expect_ev(EV_DRDY, s + 2 + HOLD + 32, "R8");
    close_scn(s + 2 + HOLD + 32);
    sync_in = 1'b0;
    bipolar = 1'b0;

    // R9: standby aborts calibration
    align();
    c = cyc;
    cur_tag = "R9";
    mon_en = 1'b1;
    cal_start = 1'b1;
    expect_ev(EV_MUX0 + 1, c + 2, "R9");
    tick(5);
    cal_start = 1'b0;
    while (cyc < c + 500) @(negedge clk);
    s = cyc;
    standby_req = 1'b1;
    expect_ev(EV_MUX0 + 0, s + 1, "R9");
    expect_ev(EV_CELO, s + 1, "R9");
    tick(2500);
    r = cyc;
    standby_req = 1'b0;
    expect_ev(EV_FRST, r + 1, "R9");
    expect_ev(EV_CEHI, r + 1, "R9");
    expect_ev(EV_DRDY, r + 1 + HOLD, "R9");
    expect_ev(EV_DRDY, r + 1 + HOLD + 32, "R9");
    close_scn(r + 1 + HOLD + 32);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule